// File: doc/BRIEF.md
# Per-Drive Seek Status Slot Tracker

This block holds the pending completion status of positioning commands for a four-drive diskette controller. Each drive owns one slot: a full flag plus two result bytes. When a seek or a recalibrate finishes on a drive, that drive's slot is loaded and its drive-busy bit in the main status register is raised. The host later issues a sense-interrupt command. The block then drains the lowest-numbered full slot and returns its two bytes. If every slot is empty, it returns the invalid-command code instead.

A completion of any other command on a drive discards that drive's pending status. When the controller leaves reset, every slot is preloaded with a fixed status, so that the four senses the host issues after a reset each find something. The command parser feeds completion events and sense requests into the block. Interrupt gating lives outside it and consumes the interrupt-clear pulse.

Top module: `seek_slot_tracker`

## Requirements
- R1: After rst_ni is deasserted, no slot is full, busy_o is 0, sense_valid_o and irq_clr_o are 0, and a sense finds nothing.
- R2: A completion event (done_i=1) whose opcode is seek (5'h0F) or recalibrate (5'h07) on drive d fills slot d with done_res0_i and done_res1_i and sets busy_o[d] from the next cycle.
- R3: A completion with any other opcode on drive d empties slot d and leaves busy_o unchanged.
- R4: A sense (sense_i=1) picks the lowest-numbered full slot. In the next cycle it gives sense_found_o=1, sense_drive_o=d and that slot's two bytes, and a one-cycle irq_clr_o. The slot is emptied and busy_o[d] is cleared.
- R5: A sense while no slot is full gives sense_found_o=0, sense_byte0_o=8'h80, sense_byte1_o=0 and sense_drive_o=0, and no irq_clr_o.
- R6: A reset-release event (ctrl_rel_i=1) fills every slot d with byte0 = 8'hC0 + d and byte1 = 0, and clears busy_o.
- R7: When a completion and a sense fall in the same cycle, the completion is applied first, so the sense can return the slot that was just loaded.
- R8: A reset-release event overrides a completion in the same cycle. A sense in that cycle sees the preloaded slots.
- R9: A second positioning completion on a drive before any sense replaces that slot's bytes.
- R10: sense_valid_o is high for exactly the one cycle after each cycle with sense_i high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_rel_i | input | 1 | Controller leaving reset, one-cycle event |
| done_i | input | 1 | Command completion event |
| done_drive_i | input | 2 | Drive of the completed command |
| done_op_i | input | 5 | Opcode of the completed command |
| done_res0_i | input | 8 | Result byte 0 of the completed command |
| done_res1_i | input | 8 | Result byte 1 of the completed command |
| sense_i | input | 1 | Sense-interrupt request |
| busy_o | output | 4 | Drive-busy bits, one per drive |
| sense_valid_o | output | 1 | Sense response strobe |
| sense_found_o | output | 1 | A full slot was drained |
| sense_drive_o | output | 2 | Drive index of the drained slot |
| sense_byte0_o | output | 8 | First response byte |
| sense_byte1_o | output | 8 | Second response byte |
| irq_clr_o | output | 1 | Interrupt-clear pulse |

## Verification
The assertions assume that ctrl_rel_i, done_i and sense_i are single-cycle events sampled on the rising edge, and that done_drive_i names an existing drive. They also assume that the load and fill checks are only required when no sense takes the same slot in that cycle. The bench drives every event for exactly one clock, starting at a falling edge, and uses only drive indices 0 to 3. It applies overlapping events only in the scenarios that exercise the same-cycle ordering rules.

// File: rtl/seek_slot_pkg.sv
package seek_slot_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 5;

  localparam logic [OP_W-1:0]   OP_SEEK     = 5'h0F;
  localparam logic [OP_W-1:0]   OP_RECAL    = 5'h07;
  localparam logic [BYTE_W-1:0] CODE_INVAL  = 8'h80;
  localparam logic [BYTE_W-1:0] RESET_BASE  = 8'hC0;

  function automatic logic is_position_op(input logic [OP_W-1:0] op);
    return (op == OP_SEEK) || (op == OP_RECAL);
  endfunction
endpackage

// File: rtl/seek_slot_cell.sv
module seek_slot_cell
  import seek_slot_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic [BYTE_W-1:0] res0_i,
  input  logic [BYTE_W-1:0] res1_i,
  input  logic              take_i,
  output logic              post_full_o,
  output logic [BYTE_W-1:0] post_b0_o,
  output logic [BYTE_W-1:0] post_b1_o,
  output logic              busy_o
);
  localparam logic [BYTE_W-1:0] FILL_B0 = BYTE_W'(RESET_BASE + IDX);

  logic              full_q;
  logic [BYTE_W-1:0] b0_q, b1_q;
  logic              busy_q;

  // state after completion/fill, seen by the sense picker
  always_comb begin
    post_full_o = full_q;
    post_b0_o   = b0_q;
    post_b1_o   = b1_q;
    if (fill_i) begin
      post_full_o = 1'b1;
      post_b0_o   = FILL_B0;
      post_b1_o   = '0;
    end else if (load_i) begin
      post_full_o = 1'b1;
      post_b0_o   = res0_i;
      post_b1_o   = res1_i;
    end else if (drop_i) begin
      post_full_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      b0_q   <= '0;
      b1_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      full_q <= post_full_o & ~take_i;
      b0_q   <= post_b0_o;
      b1_q   <= post_b1_o;
      if (fill_i || take_i) busy_q <= 1'b0;
      else if (load_i)      busy_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !fill_i && !take_i) |=> (full_q && busy_q && b0_q == $past(res0_i) && b1_q == $past(res1_i)));

  a_r3_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i && !fill_i && !load_i) |=> !full_q);

  a_r6_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !take_i) |=> (full_q && !busy_q && b0_q == FILL_B0 && b1_q == '0));
endmodule

// File: rtl/seek_slot_pick.sv
module seek_slot_pick #(
  parameter int N     = 4,
  parameter int DRV_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     full_i,
  output logic [N-1:0]     grant_o,
  output logic [DRV_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (full_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        idx_o      = DRV_W'(i);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seek_sense_resp.sv
module seek_sense_resp
  import seek_slot_pkg::*;
#(
  parameter int DRV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sense_i,
  input  logic              any_i,
  input  logic [DRV_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] b0_i,
  input  logic [BYTE_W-1:0] b1_i,
  output logic              valid_o,
  output logic              found_o,
  output logic [DRV_W-1:0]  drive_o,
  output logic [BYTE_W-1:0] byte0_o,
  output logic [BYTE_W-1:0] byte1_o,
  output logic              irq_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      found_o   <= 1'b0;
      drive_o   <= '0;
      byte0_o   <= '0;
      byte1_o   <= '0;
      irq_clr_o <= 1'b0;
    end else begin
      valid_o   <= sense_i;
      irq_clr_o <= sense_i && any_i;
      if (sense_i) begin
        found_o <= any_i;
        drive_o <= any_i ? idx_i : '0;
        byte0_o <= any_i ? b0_i : CODE_INVAL;
        byte1_o <= any_i ? b1_i : '0;
      end
    end
  end

  a_r5_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !found_o) |-> (byte0_o == CODE_INVAL && byte1_o == '0 && !irq_clr_o));

  a_r10_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_i |=> valid_o);

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sense_i |=> !valid_o);

  a_r4_clr_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |-> (valid_o && found_o));
endmodule

// File: rtl/seek_slot_tracker.sv
module seek_slot_tracker
  import seek_slot_pkg::*;
#(
  parameter int N_DRV = 4,
  localparam int DRV_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_rel_i,
  input  logic              done_i,
  input  logic [DRV_W-1:0]  done_drive_i,
  input  logic [OP_W-1:0]   done_op_i,
  input  logic [BYTE_W-1:0] done_res0_i,
  input  logic [BYTE_W-1:0] done_res1_i,
  input  logic              sense_i,
  output logic [N_DRV-1:0]  busy_o,
  output logic              sense_valid_o,
  output logic              sense_found_o,
  output logic [DRV_W-1:0]  sense_drive_o,
  output logic [BYTE_W-1:0] sense_byte0_o,
  output logic [BYTE_W-1:0] sense_byte1_o,
  output logic              irq_clr_o
);
  logic                         pos_op;
  logic [N_DRV-1:0]             load, drop, take, grant, post_full;
  logic [N_DRV-1:0][BYTE_W-1:0] post_b0, post_b1;
  logic [DRV_W-1:0]             pick_idx;
  logic                         pick_any;

  assign pos_op = is_position_op(done_op_i);

  for (genvar d = 0; d < N_DRV; d++) begin : g_slot
    logic hit;
    assign hit     = done_i && (done_drive_i == DRV_W'(d));
    assign load[d] = hit && pos_op;
    assign drop[d] = hit && !pos_op;
    assign take[d] = sense_i && grant[d];

    seek_slot_cell #(.IDX(d)) u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_i      (ctrl_rel_i),
      .load_i      (load[d]),
      .drop_i      (drop[d]),
      .res0_i      (done_res0_i),
      .res1_i      (done_res1_i),
      .take_i      (take[d]),
      .post_full_o (post_full[d]),
      .post_b0_o   (post_b0[d]),
      .post_b1_o   (post_b1[d]),
      .busy_o      (busy_o[d])
    );
  end

  seek_slot_pick #(.N(N_DRV), .DRV_W(DRV_W)) u_pick (
    .full_i  (post_full),
    .grant_o (grant),
    .idx_o   (pick_idx),
    .any_o   (pick_any)
  );

  seek_sense_resp #(.DRV_W(DRV_W)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sense_i   (sense_i),
    .any_i     (pick_any),
    .idx_i     (pick_idx),
    .b0_i      (post_b0[pick_idx]),
    .b1_i      (post_b1[pick_idx]),
    .valid_o   (sense_valid_o),
    .found_o   (sense_found_o),
    .drive_o   (sense_drive_o),
    .byte0_o   (sense_byte0_o),
    .byte1_o   (sense_byte1_o),
    .irq_clr_o (irq_clr_o)
  );

  a_r4_one_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));

  a_r4_busy_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |-> !busy_o[sense_drive_o]);

  a_r6_busy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rel_i |=> (busy_o == '0));
endmodule

// File: tb/seek_slot_tracker_bench.sv
module seek_slot_tracker_bench;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_rel_i = 1'b0;
  logic       done_i = 1'b0;
  logic [1:0] done_drive_i = '0;
  logic [4:0] done_op_i = '0;
  logic [7:0] done_res0_i = '0;
  logic [7:0] done_res1_i = '0;
  logic       sense_i = 1'b0;
  logic [3:0] busy_o;
  logic       sense_valid_o, sense_found_o, irq_clr_o;
  logic [1:0] sense_drive_o;
  logic [7:0] sense_byte0_o, sense_byte1_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  seek_slot_tracker u_seek_slot_tracker (
    .clk_i, .rst_ni, .ctrl_rel_i, .done_i, .done_drive_i, .done_op_i,
    .done_res0_i, .done_res1_i, .sense_i, .busy_o, .sense_valid_o,
    .sense_found_o, .sense_drive_o, .sense_byte0_o, .sense_byte1_o, .irq_clr_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // arm inputs at a falling edge; caller finishes with step()
  task automatic arm_done(input int d, input int op, input int b0, input int b1);
    done_i = 1'b1; done_drive_i = 2'(d); done_op_i = 5'(op);
    done_res0_i = 8'(b0); done_res1_i = 8'(b1);
  endtask

  task automatic step();
    @(negedge clk_i);
    done_i = 1'b0; sense_i = 1'b0; ctrl_rel_i = 1'b0;
  endtask

  task automatic completion(input int d, input int op, input int b0, input int b1);
    arm_done(d, op, b0, b1);
    step();
  endtask

  task automatic check_resp(input string req, input int found, input int d, input int b0, input int b1);
    chk(req, "valid", int'(sense_valid_o), 1);
    chk(req, "found", int'(sense_found_o), found);
    chk(req, "drive", int'(sense_drive_o), d);
    chk(req, "byte0", int'(sense_byte0_o), b0);
    chk(req, "byte1", int'(sense_byte1_o), b1);
    chk(req, "irq_clr", int'(irq_clr_o), found);
  endtask

  task automatic sense(input string req, input int found, input int d, input int b0, input int b1);
    sense_i = 1'b1;
    step();
    check_resp(req, found, d, b0, b1);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "valid", int'(sense_valid_o), 0);
    chk("R1", "irq_clr", int'(irq_clr_o), 0);
    sense("R1", 0, 0, 8'h80, 0);
    step();
    chk("R10", "valid drops", int'(sense_valid_o), 0);
    chk("R10", "irq_clr drops", int'(irq_clr_o), 0);
  endtask

  task automatic t_load_and_drain();
    completion(2, 5'h0F, 8'h22, 8'h33);
    chk("R2", "busy seek d2", int'(busy_o), 4'b0100);
    completion(0, 5'h07, 8'h20, 8'h11);
    chk("R2", "busy recal d0", int'(busy_o), 4'b0101);
    sense("R4", 1, 0, 8'h20, 8'h11);
    chk("R4", "busy after d0", int'(busy_o), 4'b0100);
    sense("R4", 1, 2, 8'h22, 8'h33);
    chk("R4", "busy after d2", int'(busy_o), 4'b0000);
    sense("R5", 0, 0, 8'h80, 0);
  endtask

  task automatic t_other_clears();
    completion(1, 5'h0F, 8'h21, 8'h05);
    chk("R2", "busy d1", int'(busy_o), 4'b0010);
    completion(1, 5'h06, 8'h99, 8'h98);
    chk("R3", "busy kept", int'(busy_o), 4'b0010);
    sense("R3", 0, 0, 8'h80, 0);
  endtask

  task automatic t_fill();
    ctrl_rel_i = 1'b1;
    step();
    chk("R6", "busy cleared", int'(busy_o), 0);
    for (int d = 0; d < 4; d++) sense("R6", 1, d, 8'hC0 + d, 0);
    sense("R6", 0, 0, 8'h80, 0);
  endtask

  task automatic t_same_cycle();
    arm_done(3, 5'h0F, 8'h55, 8'h66);
    sense_i = 1'b1;
    step();
    check_resp("R7", 1, 3, 8'h55, 8'h66);
    chk("R7", "busy", int'(busy_o), 0);
  endtask

  task automatic t_overwrite();
    completion(1, 5'h0F, 8'h01, 8'h02);
    completion(1, 5'h07, 8'h03, 8'h04);
    sense("R9", 1, 1, 8'h03, 8'h04);
    sense("R9", 0, 0, 8'h80, 0);
  endtask

  task automatic t_fill_priority();
    arm_done(0, 5'h0F, 8'hAA, 8'hBB);
    ctrl_rel_i = 1'b1;
    sense_i = 1'b1;
    step();
    check_resp("R8", 1, 0, 8'hC0, 0);
    chk("R8", "busy", int'(busy_o), 0);
    for (int d = 1; d < 4; d++) sense("R8", 1, d, 8'hC0 + d, 0);
    sense("R8", 0, 0, 8'h80, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load_and_drain();
    t_other_clears();
    t_fill();
    t_same_cycle();
    t_overwrite();
    t_fill_priority();
    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule